// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O port. It sits on a simple 32-bit word bus. For every group of eight pad lines it holds two registers. One stores the value the pads drive. The other selects, line by line, whether the line drives its pad or only listens to it. The number of lines is a parameter, and the last bank may be only partly populated.

Each bank's pair of registers sits at a computed address that steps over a reserved window. An interrupt block that shares the same address space uses that window. The controller never answers inside the window, so the neighbouring block can claim it. Pad inputs cross into the clock domain through a two-flop synchronizer. Reading a bank's data register gives a per-line mix: the synchronized pad level on listening lines and the stored drive value on driving lines.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every direction bit is 1 and every data bit is 0. So `pad_oe` is all zero and `pad_out` is all zero.
- R2: Bank b has base address A = (b+1)*8, and A is raised by 0x10 when it is 0x90 or above. The data register is at A and the direction register is at A+4. For example, bank 16 is at 0x88, bank 17 at 0xA0 and bank 18 at 0xA8.
- R3: For line n, direction bit 0 drives the pad: `pad_oe[n]`=1 and `pad_out[n]` equals the stored data bit. Direction bit 1 releases the pad: `pad_oe[n]`=0.
- R4: Line n is bit n mod 8 of the registers of bank n/8.
- R5: A read of a data register returns, bit by bit, the synchronized pad level where the direction bit is 1 and the stored data bit where it is 0. A data write is stored whatever the direction.
- R6: A pad level is visible through two synchronizer flops. A read sampled at the second clock edge after a pad change still returns the old level. A read sampled at the third edge returns the new level.
- R7: Register bits 31..8 read as 0, and writes to those bits have no effect.
- R8: In a partly populated last bank, bits of lines at or above the line count read 0 in both registers and ignore writes. The direction register of a 148-line bank 18 resets to 0x0F.
- R9: The controller ignores writes to any word address that is not a bank register and reads such an address as 0. This covers 0x90 to 0x9F, addresses below 0x08, addresses past the last bank and addresses that are not word-aligned.
- R10: `bus_rdata` carries the read result from the clock edge that samples the read request until the next read. A write takes effect at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_LINES | Asynchronous pad input levels |
| pad_oe | output | NUM_LINES | Pad drive enable, 1 = drive |
| pad_out | output | NUM_LINES | Pad drive value |

## Verification
A direction write and a pad transition can land in the same clock cycle. The data readback must then choose the stored value for the newly driven line and the synchronized level for the rest. The bench provokes this by writing a direction register on the same negative edge at which it changes that bank's pad inputs. After the synchronizer has settled, it reads the bank. It judges the result against a value built from the written data and the new pad levels, and it also checks `pad_oe` for that bank.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int unsigned LPB      = 8;
    localparam int unsigned RSV_LO   = 'h90;
    localparam int unsigned RSV_SPAN = 'h10;
    localparam int unsigned DIR_OFS  = 4;

    function automatic int unsigned bank_base(int unsigned b);
        int unsigned a;
        a = (b + 1) * 8;
        if (a >= RSV_LO) a = a + RSV_SPAN;
        return a;
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R6
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int unsigned VALID = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dat,
    input  logic             wr_dir,
    input  logic [VALID-1:0] wdata,
    input  logic [VALID-1:0] pin_sync,
    output logic [VALID-1:0] dir_o,
    output logic [VALID-1:0] out_o,
    output logic [LPB-1:0]   rd_dat,
    output logic [LPB-1:0]   rd_dir
);
    typedef struct packed {
        logic [VALID-1:0] dout;
        logic [VALID-1:0] dir;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_dat) st_d.dout = wdata;
        if (wr_dir) st_d.dir  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dout <= '0;
            st_q.dir  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o  = st_q.dir;
    assign out_o  = st_q.dout;
    assign rd_dat = LPB'((pin_sync & st_q.dir) | (st_q.dout & ~st_q.dir));
    assign rd_dir = LPB'(st_q.dir);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_o == $past(wdata));

    // R5
    dat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !wr_dir) |=> (out_o == $past(wdata)) && $stable(dir_o));
endmodule

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
    import gpb_pkg::*;
#(
    parameter int unsigned NBANK = 19,
    parameter int unsigned AW    = 12
) (
    input  logic [AW-1:0]    addr,
    output logic [NBANK-1:0] dat_hit,
    output logic [NBANK-1:0] dir_hit,
    output logic             any_hit
);
    for (genvar b = 0; b < NBANK; b++) begin : g_cmp
        localparam int unsigned BASE = bank_base(b);
        assign dat_hit[b] = (addr == AW'(BASE));
        assign dir_hit[b] = (addr == AW'(BASE + DIR_OFS));
    end

    assign any_hit = |{dat_hit, dir_hit};
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpb_pkg::*;
#(
    parameter int unsigned NUM_LINES = 148,
    parameter int unsigned AW        = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pad_out
);
    localparam int unsigned NBANK = (NUM_LINES + LPB - 1) / LPB;

    typedef struct packed {
        logic [31:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_LINES-1:0] pin_sync;
    logic [NBANK-1:0]     dat_hit, dir_hit;
    logic                 any_hit;
    logic [LPB-1:0]       rd_dat_all [NBANK];
    logic [LPB-1:0]       rd_dir_all [NBANK];
    logic [LPB-1:0]       rd_mux;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:LPB];

    gpb_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_sync)
    );

    gpb_addr_dec #(.NBANK(NBANK), .AW(AW)) u_dec (
        .addr    (bus_addr),
        .dat_hit (dat_hit),
        .dir_hit (dir_hit),
        .any_hit (any_hit)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int unsigned LEFT  = NUM_LINES - b * LPB;
        localparam int unsigned VALID = (LEFT >= LPB) ? LPB : LEFT;
        logic [VALID-1:0] dir_b, out_b;

        gpb_bank #(.VALID(VALID)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dat   (bus_sel && bus_wr && dat_hit[b]),
            .wr_dir   (bus_sel && bus_wr && dir_hit[b]),
            .wdata    (bus_wdata[VALID-1:0]),
            .pin_sync (pin_sync[b*LPB +: VALID]),
            .dir_o    (dir_b),
            .out_o    (out_b),
            .rd_dat   (rd_dat_all[b]),
            .rd_dir   (rd_dir_all[b])
        );

        assign pad_oe[b*LPB +: VALID]  = ~dir_b;
        assign pad_out[b*LPB +: VALID] = out_b;
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < int'(NBANK); b++) begin
            if (dat_hit[b]) rd_mux = rd_mux | rd_dat_all[b];
            if (dir_hit[b]) rd_mux = rd_mux | rd_dir_all[b];
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_sel && !bus_wr) st_d.rdata = 32'(rd_mux);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R2
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dat_hit, dir_hit}));

    // R9
    rsv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr >= AW'(RSV_LO) && bus_addr < AW'(RSV_LO + RSV_SPAN))
        |-> !any_hit);

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !any_hit) |=> bus_rdata == 32'd0);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:LPB] == '0);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
    localparam int NL = 148;
    localparam int AW = 12;
    localparam int NV = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_oe;
    logic [NL-1:0] pad_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl #(.NUM_LINES(NL), .AW(AW)) u_gpio_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    // {write, addr, wdata, expected read}
    localparam logic [76:0] VECS [NV] = '{
        {1'b1, 12'h00C, 32'h0000_0000, 32'h0},
        {1'b1, 12'h008, 32'hFFFF_FF5A, 32'h0},
        {1'b0, 12'h008, 32'h0,         32'h5A},
        {1'b0, 12'h00C, 32'h0,         32'h00},
        {1'b1, 12'h014, 32'h0000_000F, 32'h0},
        {1'b1, 12'h010, 32'h0000_00FF, 32'h0},
        {1'b0, 12'h010, 32'h0,         32'hF0},
        {1'b0, 12'h014, 32'h0,         32'h0F},
        {1'b1, 12'h08C, 32'h0000_0000, 32'h0},
        {1'b1, 12'h088, 32'h0000_003C, 32'h0},
        {1'b0, 12'h088, 32'h0,         32'h3C},
        {1'b1, 12'h0A4, 32'h0000_0000, 32'h0},
        {1'b1, 12'h0A0, 32'h0000_00C3, 32'h0},
        {1'b0, 12'h0A0, 32'h0,         32'hC3},
        {1'b0, 12'h090, 32'h0,         32'h0},
        {1'b0, 12'h094, 32'h0,         32'h0},
        {1'b0, 12'h098, 32'h0,         32'h0},
        {1'b0, 12'h09C, 32'h0,         32'h0},
        {1'b1, 12'h098, 32'h0000_00FF, 32'h0},
        {1'b1, 12'h090, 32'h0000_00FF, 32'h0},
        {1'b0, 12'h088, 32'h0,         32'h3C},
        {1'b0, 12'h0A0, 32'h0,         32'hC3},
        {1'b0, 12'h004, 32'h0,         32'h0},
        {1'b0, 12'h00A, 32'h0,         32'h0},
        {1'b0, 12'h0B0, 32'h0,         32'h0},
        {1'b0, 12'h08C, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        bus_read(12'h00C, rd); chk("R1 bank0 dir", NL'(rd), NL'(32'hFF));
        bus_read(12'h008, rd); chk("R1 bank0 data", NL'(rd), NL'(32'h00));
        // R8 partial bank 18 resets to four valid lines
        bus_read(12'h0AC, rd); chk("R8 bank18 dir reset", NL'(rd), NL'(32'h0F));

        // table walk: R2 R4 R7 R9
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][76]) begin
                bus_write(VECS[i][75:64], VECS[i][63:32]);
            end else begin
                bus_read(VECS[i][75:64], rd);
                chk($sformatf("R2 R7 R9 vec%0d", i), NL'(rd), NL'(VECS[i][31:0]));
            end
        end

        // R3 R4 pad outputs follow the bank registers
        chk("R3 oe bank0", NL'(pad_oe[7:0]), NL'(8'hFF));
        chk("R3 out bank0", NL'(pad_out[7:0]), NL'(8'h5A));
        chk("R4 oe bank1", NL'(pad_oe[15:8]), NL'(8'hF0));
        chk("R4 out bank1", NL'(pad_out[15:8]), NL'(8'hFF));
        chk("R4 out bank16", NL'(pad_out[135:128]), NL'(8'h3C));
        chk("R4 oe bank17", NL'(pad_oe[143:136]), NL'(8'hFF));
        chk("R4 out bank17", NL'(pad_out[143:136]), NL'(8'hC3));

        // R6 synchronizer latency on bank 2 (base 0x18)
        @(negedge clk);
        pad_in[23:16] = 8'hA6;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h018;
        @(negedge clk);
        @(negedge clk);
        chk("R6 second edge old", NL'(bus_rdata), NL'(32'h00));
        @(negedge clk);
        chk("R6 third edge new", NL'(bus_rdata), NL'(32'hA6));
        bus_sel = 1'b0;

        // R5 mixed readback
        bus_write(12'h018, 32'h50);
        bus_write(12'h01C, 32'h0F);
        bus_read(12'h018, rd); chk("R5 mixed", NL'(rd), NL'(32'h56));

        // R8 partial bank writes
        bus_write(12'h0AC, 32'h0);
        bus_read(12'h0AC, rd); chk("R8 dir write", NL'(rd), NL'(32'h00));
        chk("R8 oe", NL'(pad_oe[147:144]), NL'(4'hF));
        bus_write(12'h0A8, 32'hFF);
        bus_read(12'h0A8, rd); chk("R8 data write", NL'(rd), NL'(32'h0F));
        chk("R8 out", NL'(pad_out[147:144]), NL'(4'hF));

        // R9 writes to unmapped addresses change nothing
        bus_write(12'h0B0, 32'h0);
        bus_write(12'h0B4, 32'hFF);
        bus_write(12'h0AE, 32'h0);
        bus_write(12'h000, 32'h0);
        bus_read(12'h0A8, rd); chk("R9 bank18 data kept", NL'(rd), NL'(32'h0F));
        bus_read(12'h0AC, rd); chk("R9 bank18 dir kept", NL'(rd), NL'(32'h00));
        bus_read(12'h008, rd); chk("R9 bank0 data kept", NL'(rd), NL'(32'h5A));

        // R5 R10 direction write in the same cycle as a pad change (bank 3, base 0x20)
        bus_write(12'h020, 32'h01);
        pad_in[31:24] = 8'hFF;
        repeat (3) @(negedge clk);
        bus_read(12'h020, rd); chk("R5 bank3 inputs", NL'(rd), NL'(32'hFF));
        @(negedge clk);
        pad_in[31:24] = 8'h00;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h024; bus_wdata = 32'hFE;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R10 oe after write edge", NL'(pad_oe[31:24]), NL'(8'h01));
        repeat (3) @(negedge clk);
        bus_read(12'h020, rd); chk("R5 concurrent", NL'(rd), NL'(32'h01));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule